// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block turns single read and write requests from synchronous logic into correctly timed cycles on an external asynchronous static RAM of 32K bytes. The requester presents an address, a direction bit and, for writes, a data byte, and holds its valid strobe until the controller shows ready. Read results come back as a one-clock response pulse with the byte.

On the memory side the controller drives active-low chip select, write strobe and output enable, a 15-bit address, and a split data bus with a drive-enable for the bidirectional pad. Every phase length is a parameter derived from a nanosecond figure and the clock period by rounding up, with a floor of one clock.

The controller keeps the data pins from being driven by both sides. It never enables the memory's outputs during a write. It drives data only around the write strobe. After every read it waits out the memory's output release time before it accepts new work.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is asserted, chip select, write strobe and output enable are high, the data drive-enable is low, the response pulse is low and ready is low; ready rises within four clocks after reset is released.
- R2: Address, write data and direction are captured in the clock where valid and ready are both high. Changes to the request inputs while ready is low have no effect: the memory address stays stable and the stored byte is the captured one.
- R3: A read holds chip select and output enable low and the write strobe high for ceil(55 ns / period) clocks, which is 7 clocks at 8 ns. The data pins are sampled at the last of these clocks. The byte appears on the response port with a one-clock response pulse in the clock that follows.
- R4: A write holds output enable high throughout and the write strobe low for exactly 5 clocks at 8 ns. Data is driven from one clock before the strobe falls until one clock after it rises.
- R5: At the rising edge of the write strobe, the strobe has been low for at least 40 ns, data has been driven for at least 25 ns and the address has been stable with chip select low for at least 45 ns.
- R6: After a read the controller drives no data for ceil(20 ns / period) clocks, which is 3 clocks at 8 ns, after output enable rises. In no clock does the controller drive data while the memory may still drive.
- R7: Ready is high only when idle. After acceptance it stays low for 11 clocks for a read and 7 clocks for a write at the default timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-clock read result pulse |
| rsp_rdata | output | 8 | Read byte |
| mem_addr | output | 15 | Address to the memory |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 8 | Data toward the memory |
| mem_dq_oe | output | 1 | Pad drive-enable for mem_dq_out |
| mem_dq_in | input | 8 | Data from the memory |

## Verification
The release of the data bus by the memory after a read can overlap with the controller starting to drive write data. The bench provokes this by issuing a write in the very clock ready returns after a read, with the request already waiting. A behavioural memory keeps driving for a release window after output enable rises and returns wrong bytes until the access time has elapsed. It counts every clock in which both sides drive, so a shortened turnaround or an early sample is reported at the ports.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACCESS,
    ST_RD_CAPTURE,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_RECOVER,
    ST_TURN
  } ctrl_state_e;

  // Round a nanosecond figure up to whole clocks, never below one.
  function automatic int unsigned ns_to_clk(input int unsigned ns, input int unsigned period);
    int unsigned c;
    c = (ns + period - 1) / period;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sram_ctrl_phase_timer.sv
module sram_ctrl_phase_timer #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned RD_CLKS = 7,
  parameter int unsigned WP_CLKS = 5,
  parameter int unsigned TA_CLKS = 3,
  parameter int unsigned CNT_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             cnt_done,
  output logic             cnt_load,
  output logic [CNT_W-1:0] cnt_val,
  output logic             accept,
  output logic             capture,
  output logic             req_ready,
  output logic             mem_ce_n,
  output logic             mem_we_n,
  output logic             mem_oe_n,
  output logic             mem_dq_oe
);

  localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CLKS - 1);
  localparam logic [CNT_W-1:0] WP_LOAD = CNT_W'(WP_CLKS - 1);
  localparam logic [CNT_W-1:0] TA_LOAD = CNT_W'(TA_CLKS - 1);

  ctrl_state_e state_q;
  ctrl_state_e state_d;
  logic        ready_q;
  logic        ce_n_d, we_n_d, oe_n_d, dq_oe_d, ready_d;

  assign accept  = req_valid && ready_q;
  assign capture = (state_q == ST_RD_ACCESS) && cnt_done;

  // Next-state decode
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:       if (accept) state_d = req_write ? ST_WR_SETUP : ST_RD_ACCESS;
      ST_RD_ACCESS:  if (cnt_done) state_d = ST_RD_CAPTURE;
      ST_RD_CAPTURE: state_d = ST_TURN;
      ST_TURN:       if (cnt_done) state_d = ST_IDLE;
      ST_WR_SETUP:   state_d = ST_WR_PULSE;
      ST_WR_PULSE:   if (cnt_done) state_d = ST_WR_RECOVER;
      ST_WR_RECOVER: state_d = ST_IDLE;
      default:       state_d = ST_IDLE;
    endcase
  end

  // Phase counter load on every state change
  always_comb begin
    cnt_load = (state_d != state_q);
    unique case (state_d)
      ST_RD_ACCESS: cnt_val = RD_LOAD;
      ST_WR_PULSE:  cnt_val = WP_LOAD;
      ST_TURN:      cnt_val = TA_LOAD;
      default:      cnt_val = '0;
    endcase
  end

  // Output decode from the next state, registered below
  always_comb begin
    ce_n_d  = (state_d == ST_IDLE) || (state_d == ST_RD_CAPTURE) || (state_d == ST_TURN);
    oe_n_d  = (state_d != ST_RD_ACCESS);
    we_n_d  = (state_d != ST_WR_PULSE);
    dq_oe_d = (state_d == ST_WR_SETUP) || (state_d == ST_WR_PULSE) ||
              (state_d == ST_WR_RECOVER);
    ready_d = (state_d == ST_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      ready_q   <= 1'b0;
      mem_ce_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
    end else begin
      state_q   <= state_d;
      ready_q   <= ready_d;
      mem_ce_n  <= ce_n_d;
      mem_we_n  <= we_n_d;
      mem_oe_n  <= oe_n_d;
      mem_dq_oe <= dq_oe_d;
    end
  end

  assign req_ready = ready_q;

endmodule

// File: rtl/sram_ctrl_dpath.sv
module sram_ctrl_dpath #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  // Request capture: held for the whole memory cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (accept) begin
      mem_addr   <= req_addr;
      mem_dq_out <= req_wdata;
    end
  end

  // Read sample at the end of the access phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_rdata <= '0;
    end else if (capture) begin
      rsp_rdata <= mem_dq_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= capture;
    end
  end

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CLK_NS    = 8,
  parameter int unsigned ADDR_W    = 15,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned T_RC_NS   = 55,
  parameter int unsigned T_AA_NS   = 55,
  parameter int unsigned T_DOE_NS  = 25,
  parameter int unsigned T_HZOE_NS = 20,
  parameter int unsigned T_PWE_NS  = 40,
  parameter int unsigned T_SD_NS   = 25,
  parameter int unsigned T_AW_NS   = 45
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  // Phase lengths in clocks
  localparam int unsigned RD_CLKS  = max3(ns_to_clk(T_AA_NS, CLK_NS),
                                          ns_to_clk(T_DOE_NS, CLK_NS),
                                          ns_to_clk(T_RC_NS, CLK_NS));
  // One setup clock precedes the strobe, so address-to-end needs one less
  localparam int unsigned AW_CLKS  = ns_to_clk(T_AW_NS, CLK_NS) - 1;
  localparam int unsigned WP_CLKS  = max3(ns_to_clk(T_PWE_NS, CLK_NS),
                                          ns_to_clk(T_SD_NS, CLK_NS), AW_CLKS);
  localparam int unsigned TA_CLKS  = ns_to_clk(T_HZOE_NS, CLK_NS);
  localparam int unsigned MAX_CLKS = max3(RD_CLKS, WP_CLKS, TA_CLKS);
  localparam int unsigned CNT_W    = $clog2(MAX_CLKS + 1);

  // Asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_core_n = rst_sync_q[1];

  logic             cnt_load;
  logic [CNT_W-1:0] cnt_val;
  logic             cnt_done;
  logic             accept;
  logic             capture;

  sram_ctrl_phase_timer #(
    .CNT_W(CNT_W)
  ) i_timer (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .done     (cnt_done)
  );

  sram_ctrl_fsm #(
    .RD_CLKS(RD_CLKS),
    .WP_CLKS(WP_CLKS),
    .TA_CLKS(TA_CLKS),
    .CNT_W  (CNT_W)
  ) i_fsm (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .cnt_done  (cnt_done),
    .cnt_load  (cnt_load),
    .cnt_val   (cnt_val),
    .accept    (accept),
    .capture   (capture),
    .req_ready (req_ready),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_oe (mem_dq_oe)
  );

  sram_ctrl_dpath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) i_dpath (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .accept     (accept),
    .capture    (capture),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int unsigned ADDR_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe
);

  AST_STROBE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n)); // R4

  AST_DRIVE_BEFORE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> ($past(mem_dq_oe) && mem_dq_oe)); // R4

  AST_DRIVE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_dq_oe); // R4

  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe); // R6

  AST_TURN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |=> !mem_dq_oe); // R6

  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R3

  AST_RSP_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!mem_oe_n)); // R3

  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R7

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable(mem_addr)); // R2

endmodule

bind sram_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_addr  (mem_addr),
  .mem_ce_n  (mem_ce_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/test_sram_ctrl.sv
`timescale 1ns/1ps
module test_sram_ctrl;

  localparam int CLK_NS = 8;
  localparam int RD     = (55 + CLK_NS - 1) / CLK_NS;  // 7
  localparam int WP     = 5;
  localparam int TA     = (20 + CLK_NS - 1) / CLK_NS;  // 3
  localparam int RD_BUSY = RD + 1 + TA;                // 11
  localparam int WR_BUSY = 1 + WP + 1;                 // 7

  logic        clk;
  logic        rst_n;
  logic        req_valid, req_ready, req_write;
  logic [14:0] req_addr;
  logic [7:0]  req_wdata;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [14:0] mem_addr;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_out, mem_dq_in;

  sram_ctrl i_sram_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural memory ----------------
  logic [7:0]  ram    [int];
  logic [7:0]  shadow [int];
  logic [7:0]  exp_q  [$];
  logic [14:0] addr_q;
  bit          rd_act, rd_act_q, wr_act, wr_act_q, ce_q;
  int          rd_t0, rd_cnt, rel_cnt, we_cnt, dq_cnt, aw_cnt, contention;

  initial begin
    mem_dq_in = 8'hA5;
    rd_act_q = 0; wr_act_q = 0; ce_q = 0; addr_q = '0;
    rd_t0 = 0; rd_cnt = 0; rel_cnt = 0; we_cnt = 0; dq_cnt = 0; aw_cnt = 0;
    contention = 0;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      rd_act = !mem_ce_n && mem_we_n && !mem_oe_n;
      wr_act = !mem_ce_n && !mem_we_n;
      if (mem_dq_oe && (rd_act || rel_cnt > 0)) begin
        contention++;
        $display("FAIL R6 both sides drive at %0t actual=1 expected=0", $time);
      end
      if (rd_act && !rd_act_q) rd_t0 = int'($time) - CLK_NS / 2;
      if (rd_act && rd_act_q) chk(mem_addr == addr_q, "R2", "read address stable", mem_addr, addr_q);
      if (!rd_act && rd_act_q) chk(rd_cnt == RD, "R3", "output enable clocks", rd_cnt, RD);
      if (rd_act) begin
        if (int'($time) + CLK_NS / 2 - rd_t0 >= 55 && ram.exists(int'(mem_addr)))
          mem_dq_in = ram[int'(mem_addr)];
        else if (ram.exists(int'(mem_addr)))
          mem_dq_in = ~ram[int'(mem_addr)];
        else
          mem_dq_in = 8'h5A;
      end else if (rel_cnt > 0) begin
        mem_dq_in = 8'h3C;
      end else begin
        mem_dq_in = 8'hA5;
      end
      if (!wr_act && wr_act_q) begin
        chk(we_cnt == WP, "R4", "strobe clocks", we_cnt, WP);
        chk(we_cnt * CLK_NS >= 40, "R5", "strobe ns", we_cnt * CLK_NS, 40);
        chk(dq_cnt * CLK_NS >= 25, "R5", "data setup ns", dq_cnt * CLK_NS, 25);
        chk(aw_cnt * CLK_NS >= 45, "R5", "address setup ns", aw_cnt * CLK_NS, 45);
        chk(mem_dq_oe == 1'b1, "R4", "data held after strobe", mem_dq_oe, 1);
        ram[int'(mem_addr)] = mem_dq_out;
      end
      rd_cnt  = rd_act ? rd_cnt + 1 : 0;
      rel_cnt = rd_act ? TA : (rel_cnt > 0 ? rel_cnt - 1 : 0);
      we_cnt  = wr_act ? we_cnt + 1 : 0;
      dq_cnt  = mem_dq_oe ? dq_cnt + 1 : 0;
      aw_cnt  = !mem_ce_n ? ((ce_q && mem_addr == addr_q) ? aw_cnt + 1 : 1) : 0;
      rd_act_q = rd_act; wr_act_q = wr_act; ce_q = !mem_ce_n; addr_q = mem_addr;
    end
  end

  // ---------------- scoreboard monitor ----------------
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3", "unexpected response", rsp_rdata, 0);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(rsp_rdata == e, "R3", "read data", rsp_rdata, e);
      end
    end
  end

  // ---------------- driver ----------------
  task automatic xfer(input bit wr, input logic [14:0] a, input logic [7:0] d);
    int n;
    int rsp_at;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    if (wr) shadow[int'(a)] = d;
    else    exp_q.push_back(shadow[int'(a)]);
    @(negedge clk);
    // scramble the inputs while busy: must have no effect (R2)
    req_valid = 1'b0; req_write = !wr; req_addr = ~a; req_wdata = ~d;
    n = 1; rsp_at = 0;
    chk(!req_ready, "R7", "ready after accept", req_ready, 0);
    if (rsp_valid) rsp_at = n;
    while (!req_ready && n < 100) begin
      @(negedge clk);
      n++;
      if (rsp_valid) rsp_at = n;
    end
    if (wr) begin
      chk(n - 1 == WR_BUSY, "R7", "write busy clocks", n - 1, WR_BUSY);
    end else begin
      chk(n - 1 == RD_BUSY, "R7", "read busy clocks", n - 1, RD_BUSY);
      chk(rsp_at == RD + 1, "R3", "response clock", rsp_at, RD + 1);
    end
  endtask

  initial begin
    #(200000 * CLK_NS);
    checks++; errors++;
    $display("FAIL R7 watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk(mem_ce_n == 1'b1, "R1", "reset chip select", mem_ce_n, 1);
    chk(mem_we_n == 1'b1, "R1", "reset strobe", mem_we_n, 1);
    chk(mem_oe_n == 1'b1, "R1", "reset output enable", mem_oe_n, 1);
    chk(mem_dq_oe == 1'b0, "R1", "reset drive", mem_dq_oe, 0);
    chk(rsp_valid == 1'b0, "R1", "reset response", rsp_valid, 0);
    chk(req_ready == 1'b0, "R1", "reset ready", req_ready, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);

    // corner addresses and patterns
    xfer(1'b1, 15'h0000, 8'h00);
    xfer(1'b1, 15'h7FFF, 8'hFF);
    xfer(1'b1, 15'h1234, 8'hA5);
    xfer(1'b0, 15'h7FFF, 8'h00);
    xfer(1'b0, 15'h0000, 8'h00);
    xfer(1'b0, 15'h1234, 8'h00);
    // read immediately followed by a write: turnaround window (R6)
    xfer(1'b0, 15'h1234, 8'h00);
    xfer(1'b1, 15'h4321, 8'h5C);
    xfer(1'b0, 15'h4321, 8'h00);
    // overwrite then read back at once
    xfer(1'b1, 15'h1234, 8'h69);
    xfer(1'b0, 15'h1234, 8'h00);
    // a sweep written forward, read backward
    for (int i = 0; i < 16; i++) xfer(1'b1, 15'(i * 2049), 8'(i * 17 + 3));
    for (int i = 15; i >= 0; i--) xfer(1'b0, 15'(i * 2049), 8'h00);

    repeat (4) @(negedge clk);
    chk(contention == 0, "R6", "clocks with both sides driving", contention, 0);
    chk(exp_q.size() == 0, "R3", "responses outstanding", exp_q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule